// File: doc/BRIEF.md
# SPI Master Packet Sequencer

This block drives the master side of an SPI link. A transfer is framed as a packet of bytes repeated a programmed number of times. Both counts are written as value minus one. The engine drives chip select low, waits a programmed setup time, and shifts whole bytes. Each byte to send is pulled from a byte stream with a valid/ready handshake. Each received byte is pushed onto an output stream in the cycle after its last bit is sampled. When the frame ends, the engine waits a programmed hold time. In normal mode it then releases chip select and keeps it released for a programmed idle gap before it accepts the next start.

SCK high time, SCK low time, clock polarity, clock phase and the bit order of each direction are set from configuration inputs. With pause mode on, the end of a frame leaves chip select asserted, so software can chain segments. It issues resume to run one more frame under the same select. A software reset command brings the engine back to idle with chip select released. Two sticky status flags record finish and pause, and both clear when status is read. The interrupt output follows the enabled flags.

All times are counted in system clock cycles. Configuration and command inputs are sampled on the rising clock edge. Commands are one-cycle pulses.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset, cs_n is 1, busy is 0, tx_ready is 0, stat_rdata is 0, irq is 0, and sck equals cfg_cpol.
- R2: Within a byte, every SCK high phase lasts cfg_sck_hi+1 cycles and every SCK low phase lasts cfg_sck_lo+1 cycles.
- R3: Timing in mode 0 (cpol 0, cpha 0):
  - The first SCK rise comes cfg_cs_setup+cfg_sck_lo+3 cycles after cs_n falls.
  - cs_n rises cfg_cs_hold+2 cycles after the last SCK fall.
  - After a finish, busy stays 1 with cs_n high for cfg_cs_idle+1 cycles.
- R4: A frame consumes and returns exactly (cfg_pkt_len+1)*(cfg_pkt_loop+1) bytes. tx_ready is only ever 1 while cs_n is 0.
- R5: cmd_act starts a frame only from idle. A cmd_act while busy is ignored, and the frame length does not change.
- R6: Pause mode (cfg_pause_en=1):
  - The end of a frame leaves cs_n at 0 and busy at 1, and sets stat_rdata bit 1.
  - cmd_resume then runs one more full frame.
  - cmd_act while paused is ignored.
  - cmd_resume while not paused is ignored.
- R7: With cfg_pause_en=0, the end of a frame sets stat_rdata bit 0 in the same cycle that cs_n returns to 1. Whenever busy is 0, cs_n is 1.
- R8: cmd_rst returns the engine to idle with cs_n at 1 in the next cycle, from any state including paused.
- R9: SCK idles at cfg_cpol. With cfg_cpha=0, MISO is sampled on the leading SCK edge. With cfg_cpha=1, it is sampled on the trailing edge, and MOSI changes on the leading edge. A MOSI-to-MISO loopback therefore returns the sent bits in all four modes.
- R10: Bit order:
  - cfg_tx_msb=1 sends bit 7 first; 0 sends bit 0 first.
  - cfg_rx_msb=1 places the first received bit in bit 7; 0 places it in bit 0.
  - Under loopback, differing settings return each byte bit-reversed.
- R11: rx_valid is a one-cycle pulse per received byte.
- R12: stat_rdata bit 0 is finish and bit 1 is pause. A stat_rd pulse clears both. irq is high exactly while (bit 0 and cfg_fin_ie) or (bit 1 and cfg_pause_ie).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_act | input | 1 | Start pulse, accepted in idle |
| cmd_resume | input | 1 | Continue pulse, accepted when paused |
| cmd_rst | input | 1 | Software reset pulse |
| cfg_pause_en | input | 1 | Keep select asserted at frame end |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Sample on trailing edge when 1 |
| cfg_tx_msb | input | 1 | Transmit MSB first when 1 |
| cfg_rx_msb | input | 1 | Receive MSB first when 1 |
| cfg_fin_ie | input | 1 | Finish interrupt enable |
| cfg_pause_ie | input | 1 | Pause interrupt enable |
| cfg_sck_hi | input | 8 | SCK high cycles minus one |
| cfg_sck_lo | input | 8 | SCK low cycles minus one |
| cfg_cs_setup | input | 8 | Select-to-clock setup cycles minus one |
| cfg_cs_hold | input | 8 | Clock-to-deselect hold cycles minus one |
| cfg_cs_idle | input | 8 | Minimum deselected gap minus one |
| cfg_pkt_len | input | 10 | Bytes per packet minus one |
| cfg_pkt_loop | input | 8 | Packet repetitions minus one |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Engine takes tx_data this cycle |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data valid pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Engine not idle |
| stat_rd | input | 1 | Status read pulse, clears flags |
| stat_rdata | output | 2 | Bit 1 pause, bit 0 finish |
| irq | output | 1 | Interrupt request |

## Verification
Frames run with MOSI looped back to MISO in all four clock modes and in every bit-order pairing. Matching orders must return the sent bytes, and mismatched orders must return them bit-reversed, which separates the sampling edge from the shift direction. Two timing sets with different high, low, setup, hold and idle values show that each count reaches its own interval. A multi-packet, multi-loop frame exposes framing arithmetic errors through the byte count. Pause and resume, stray commands, and masked interrupts show which commands are accepted in which state.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SETUP, SQ_XFER, SQ_HOLD, SQ_PAUSED, SQ_GAP
  } seq_state_e;

  localparam int STAT_W         = 2;
  localparam int STAT_FIN_BIT   = 0;
  localparam int STAT_PAUSE_BIT = 1;
endpackage

// File: rtl/spi_pkt_bitengine.sv
module spi_pkt_bitengine #(
  parameter int DW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start,
  input  logic [DW-1:0] start_data,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          tx_msb,
  input  logic          rx_msb,
  input  logic [TW-1:0] hi_cyc,
  input  logic [TW-1:0] lo_cyc,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid
);
  localparam int BCW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  logic          act_q, act_d;
  logic          half_q, half_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [DW-1:0] txsh_q, txsh_d;
  logic [DW-1:0] rxsh_q, rxsh_d;
  logic          sck_q, sck_d;
  logic          mosi_q, mosi_d;
  logic          done_q, done_d;
  logic [DW-1:0] rxd_q, rxd_d;
  logic          rxv_q, rxv_d;

  logic [TW-1:0] dur_a, dur_b;
  logic          tx_cur, do_sample;
  logic [DW-1:0] tx_shifted, rx_in;

  // First half of each bit sits at the idle level, the second half at the opposite level
  assign dur_a      = cpol ? hi_cyc : lo_cyc;
  assign dur_b      = cpol ? lo_cyc : hi_cyc;
  assign tx_cur     = tx_msb ? txsh_q[DW-1] : txsh_q[0];
  assign tx_shifted = tx_msb ? {txsh_q[DW-2:0], 1'b0} : {1'b0, txsh_q[DW-1:1]};
  assign rx_in      = rx_msb ? {rxsh_q[DW-2:0], miso} : {miso, rxsh_q[DW-1:1]};

  always_comb begin
    act_d     = act_q;
    half_d    = half_q;
    bit_d     = bit_q;
    tmr_d     = tmr_q;
    txsh_d    = txsh_q;
    rxsh_d    = rxsh_q;
    sck_d     = sck_q;
    mosi_d    = mosi_q;
    done_d    = 1'b0;
    rxd_d     = rxd_q;
    rxv_d     = 1'b0;
    do_sample = 1'b0;
    if (abort) begin
      act_d = 1'b0;
      sck_d = cpol;
    end else if (!act_q) begin
      sck_d = cpol;
      if (start) begin
        act_d  = 1'b1;
        half_d = 1'b0;
        bit_d  = '0;
        tmr_d  = dur_a;
        txsh_d = start_data;
        if (!cpha) mosi_d = tx_msb ? start_data[DW-1] : start_data[0];
      end
    end else if (tmr_q != '0) begin
      tmr_d = tmr_q - TW'(1);
    end else if (!half_q) begin
      // leading edge
      half_d = 1'b1;
      tmr_d  = dur_b;
      sck_d  = ~cpol;
      if (cpha) mosi_d = tx_cur;
      else      do_sample = 1'b1;
    end else begin
      // trailing edge
      sck_d     = cpol;
      txsh_d    = tx_shifted;
      do_sample = cpha;
      if (bit_q == LAST_BIT) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        bit_d  = bit_q + BCW'(1);
        half_d = 1'b0;
        tmr_d  = dur_a;
        if (!cpha) mosi_d = tx_msb ? tx_shifted[DW-1] : tx_shifted[0];
      end
    end
    if (do_sample) begin
      rxsh_d = rx_in;
      if (bit_q == LAST_BIT) begin
        rxd_d = rx_in;
        rxv_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
      tmr_q  <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      rxd_q  <= '0;
      rxv_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      half_q <= half_d;
      bit_q  <= bit_d;
      tmr_q  <= tmr_d;
      txsh_q <= txsh_d;
      rxsh_q <= rxsh_d;
      sck_q  <= sck_d;
      mosi_q <= mosi_d;
      done_q <= done_d;
      rxd_q  <= rxd_d;
      rxv_q  <= rxv_d;
    end
  end

  assign sck      = sck_q;
  assign mosi     = mosi_q;
  assign busy     = act_q;
  assign done     = done_q;
  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;
endmodule

// File: rtl/spi_pkt_seq.sv
module spi_pkt_seq
  import spi_pkt_pkg::*;
#(
  parameter int TW     = 8,
  parameter int LEN_W  = 10,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_act,
  input  logic              cmd_resume,
  input  logic              cmd_rst,
  input  logic              pause_en,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [LOOP_W-1:0] loop_m1,
  input  logic [TW-1:0]     setup_m1,
  input  logic [TW-1:0]     hold_m1,
  input  logic [TW-1:0]     idle_m1,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              eng_start,
  output logic              eng_abort,
  output logic              cs_n,
  output logic              busy,
  output logic              set_fin,
  output logic              set_pause
);
  localparam int CNT_W = LEN_W + LOOP_W + 1;

  seq_state_e       st_q, st_d;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             csn_q, csn_d;

  logic [LEN_W:0]   plen;
  logic [LOOP_W:0]  ploop;
  logic [CNT_W-1:0] total;

  assign plen  = {1'b0, len_m1} + 1'b1;
  assign ploop = {1'b0, loop_m1} + 1'b1;
  assign total = CNT_W'(plen) * CNT_W'(ploop);

  assign tx_ready  = (st_q == SQ_XFER) && !eng_busy && (rem_q != '0) && !cmd_rst;
  assign eng_start = tx_ready && tx_valid;
  assign eng_abort = cmd_rst;

  always_comb begin
    st_d      = st_q;
    tmr_d     = tmr_q;
    rem_d     = rem_q;
    csn_d     = csn_q;
    set_fin   = 1'b0;
    set_pause = 1'b0;
    if (cmd_rst) begin
      st_d  = SQ_IDLE;
      tmr_d = '0;
      rem_d = '0;
      csn_d = 1'b1;
    end else begin
      case (st_q)
        SQ_IDLE: begin
          if (cmd_act) begin
            st_d  = SQ_SETUP;
            tmr_d = setup_m1;
            rem_d = total;
            csn_d = 1'b0;
          end
        end
        SQ_SETUP: begin
          if (tmr_q == '0) st_d = SQ_XFER;
          else             tmr_d = tmr_q - TW'(1);
        end
        SQ_XFER: begin
          if (eng_start) rem_d = rem_q - CNT_W'(1);
          if (eng_done && rem_q == '0) begin
            st_d  = SQ_HOLD;
            tmr_d = hold_m1;
          end
        end
        SQ_HOLD: begin
          if (tmr_q != '0) begin
            tmr_d = tmr_q - TW'(1);
          end else if (pause_en) begin
            st_d      = SQ_PAUSED;
            set_pause = 1'b1;
          end else begin
            st_d    = SQ_GAP;
            csn_d   = 1'b1;
            tmr_d   = idle_m1;
            set_fin = 1'b1;
          end
        end
        SQ_PAUSED: begin
          if (cmd_resume) begin
            st_d  = SQ_XFER;
            rem_d = total;
          end
        end
        SQ_GAP: begin
          if (tmr_q == '0) st_d = SQ_IDLE;
          else             tmr_d = tmr_q - TW'(1);
        end
        default: begin
          st_d  = SQ_IDLE;
          csn_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      tmr_q <= '0;
      rem_q <= '0;
      csn_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      rem_q <= rem_d;
      csn_q <= csn_d;
    end
  end

  assign cs_n = csn_q;
  assign busy = (st_q != SQ_IDLE);
endmodule

// File: rtl/spi_pkt_status.sv
module spi_pkt_status
  import spi_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_fin,
  input  logic              set_pause,
  input  logic              rd,
  input  logic              fin_ie,
  input  logic              pause_ie,
  output logic [STAT_W-1:0] flags,
  output logic              irq
);
  logic [STAT_W-1:0] flg_q, flg_d, set_vec, en_vec;

  always_comb begin
    set_vec                 = '0;
    set_vec[STAT_FIN_BIT]   = set_fin;
    set_vec[STAT_PAUSE_BIT] = set_pause;
    en_vec                  = '0;
    en_vec[STAT_FIN_BIT]    = fin_ie;
    en_vec[STAT_PAUSE_BIT]  = pause_ie;
    // a new event in the read cycle survives the clear
    flg_d = (rd ? '0 : flg_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
  assign irq   = |(flg_q & en_vec);
endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master
  import spi_pkt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TIME_W = 8,
  parameter int LEN_W  = 10,
  parameter int LOOP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_act,
  input  logic              cmd_resume,
  input  logic              cmd_rst,
  input  logic              cfg_pause_en,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_tx_msb,
  input  logic              cfg_rx_msb,
  input  logic              cfg_fin_ie,
  input  logic              cfg_pause_ie,
  input  logic [TIME_W-1:0] cfg_sck_hi,
  input  logic [TIME_W-1:0] cfg_sck_lo,
  input  logic [TIME_W-1:0] cfg_cs_setup,
  input  logic [TIME_W-1:0] cfg_cs_hold,
  input  logic [TIME_W-1:0] cfg_cs_idle,
  input  logic [LEN_W-1:0]  cfg_pkt_len,
  input  logic [LOOP_W-1:0] cfg_pkt_loop,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic              busy,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              irq
);
  logic eng_busy, eng_done, eng_start, eng_abort;
  logic set_fin, set_pause;

  spi_pkt_seq #(.TW(TIME_W), .LEN_W(LEN_W), .LOOP_W(LOOP_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_act   (cmd_act),
    .cmd_resume(cmd_resume),
    .cmd_rst   (cmd_rst),
    .pause_en  (cfg_pause_en),
    .len_m1    (cfg_pkt_len),
    .loop_m1   (cfg_pkt_loop),
    .setup_m1  (cfg_cs_setup),
    .hold_m1   (cfg_cs_hold),
    .idle_m1   (cfg_cs_idle),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .eng_start (eng_start),
    .eng_abort (eng_abort),
    .cs_n      (cs_n),
    .busy      (busy),
    .set_fin   (set_fin),
    .set_pause (set_pause)
  );

  spi_pkt_bitengine #(.DW(DATA_W), .TW(TIME_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (eng_abort),
    .start     (eng_start),
    .start_data(tx_data),
    .cpol      (cfg_cpol),
    .cpha      (cfg_cpha),
    .tx_msb    (cfg_tx_msb),
    .rx_msb    (cfg_rx_msb),
    .hi_cyc    (cfg_sck_hi),
    .lo_cyc    (cfg_sck_lo),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .busy      (eng_busy),
    .done      (eng_done),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid)
  );

  spi_pkt_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_fin  (set_fin),
    .set_pause(set_pause),
    .rd       (stat_rd),
    .fin_ie   (cfg_fin_ie),
    .pause_ie (cfg_pause_ie),
    .flags    (stat_rdata),
    .irq      (irq)
  );
endmodule

// File: rtl/spi_pkt_master_chk.sv
module spi_pkt_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       busy,
  input logic       rx_valid,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       irq,
  input logic [1:0] stat_rdata,
  input logic       cmd_rst,
  input logic       cfg_cpol
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cs_n && $past(cs_n) && $stable(cfg_cpol) |-> sck == cfg_cpol); // R9
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R11
  AST_TX_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |-> !cs_n); // R4
  AST_PAUSE_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[1]) |-> !cs_n && busy); // R6
  AST_FINISH_RELEASES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_rdata[0]) |-> cs_n); // R7
  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n); // R7
  AST_SW_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> cs_n && !busy); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_rdata != 2'b00); // R12
endmodule

bind spi_pkt_master spi_pkt_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sck       (sck),
  .busy      (busy),
  .rx_valid  (rx_valid),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .irq       (irq),
  .stat_rdata(stat_rdata),
  .cmd_rst   (cmd_rst),
  .cfg_cpol  (cfg_cpol)
);

// File: tb/tb_spi_pkt_master.sv
module tb_spi_pkt_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cmd_act = 1'b0, cmd_resume = 1'b0, cmd_rst = 1'b0;
  logic       cfg_pause_en = 1'b0, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic       cfg_tx_msb = 1'b1, cfg_rx_msb = 1'b1;
  logic       cfg_fin_ie = 1'b1, cfg_pause_ie = 1'b1;
  logic [7:0] cfg_sck_hi = 8'd1, cfg_sck_lo = 8'd2;
  logic [7:0] cfg_cs_setup = 8'd3, cfg_cs_hold = 8'd1, cfg_cs_idle = 8'd4;
  logic [9:0] cfg_pkt_len = 10'd3;
  logic [7:0] cfg_pkt_loop = 8'd0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid, sck, mosi, cs_n, busy, irq;
  logic       stat_rd = 1'b0;
  logic [1:0] stat_rdata;
  wire        miso_w = mosi;

  spi_pkt_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .cmd_resume(cmd_resume),
    .cmd_rst(cmd_rst), .cfg_pause_en(cfg_pause_en), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_tx_msb(cfg_tx_msb), .cfg_rx_msb(cfg_rx_msb),
    .cfg_fin_ie(cfg_fin_ie), .cfg_pause_ie(cfg_pause_ie),
    .cfg_sck_hi(cfg_sck_hi), .cfg_sck_lo(cfg_sck_lo),
    .cfg_cs_setup(cfg_cs_setup), .cfg_cs_hold(cfg_cs_hold),
    .cfg_cs_idle(cfg_cs_idle), .cfg_pkt_len(cfg_pkt_len),
    .cfg_pkt_loop(cfg_pkt_loop), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .sck(sck),
    .mosi(mosi), .miso(miso_w), .cs_n(cs_n), .busy(busy),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  logic [7:0] txmem [64];
  logic [7:0] rxmem [64];
  int  tx_idx = 0, rx_cnt = 0;
  bit  fire = 1'b0;

  // byte source
  initial begin
    for (int i = 0; i < 64; i++) txmem[i] = 8'(8'h5A ^ (i * 37));
    forever begin
      @(negedge clk);
      if (fire) tx_idx++;
      tx_data  = txmem[tx_idx & 63];
      tx_valid = 1'b1;
      fire     = tx_ready;
    end
  end

  // observers
  int  run = 0, first_edge = 0, hi_min = 0, hi_max = 0, lo_min = 0, tail = 0, gapc = 0;
  bit  seen_edge = 1'b0;
  logic prev_sck = 1'b0, prev_cs = 1'b1;
  always @(negedge clk) begin
    if (rx_valid) begin
      rxmem[rx_cnt & 63] = rx_data;
      rx_cnt++;
    end
    if (!cs_n) begin
      if (prev_cs) begin
        run = 1; seen_edge = 1'b0; hi_min = 999; hi_max = 0; lo_min = 999; gapc = 0;
      end else if (sck != prev_sck) begin
        if (!seen_edge) first_edge = run;
        else if (prev_sck) begin
          if (run < hi_min) hi_min = run;
          if (run > hi_max) hi_max = run;
        end else if (run < lo_min) lo_min = run;
        seen_edge = 1'b1;
        run = 1;
      end else run++;
    end else begin
      if (!prev_cs) tail = run;
      if (busy) gapc++;
    end
    prev_sck = sck;
    prev_cs  = cs_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  task automatic pulse_act();
    @(negedge clk); cmd_act = 1'b1; @(negedge clk); cmd_act = 1'b0;
  endtask
  task automatic pulse_resume();
    @(negedge clk); cmd_resume = 1'b1; @(negedge clk); cmd_resume = 1'b0;
  endtask
  task automatic pulse_rst();
    @(negedge clk); cmd_rst = 1'b1; @(negedge clk); cmd_rst = 1'b0;
  endtask
  task automatic read_stat();
    @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
  endtask
  task automatic wait_flag();
    int k = 0;
    do begin @(negedge clk); k++; end while (stat_rdata == 2'b00 && k < 40000);
    if (k >= 40000) chk("R7 flag timeout", 0, 1);
  endtask
  task automatic wait_idle();
    int k = 0;
    while (busy && k < 2000) begin @(negedge clk); k++; end
  endtask

  // start a frame and check bytes consumed and returned
  task automatic run_frame(input string req, input int nbytes, input bit use_act);
    int t0 = tx_idx;
    int r0 = rx_cnt;
    if (use_act) pulse_act(); else pulse_resume();
    wait_flag();
    repeat (2) @(negedge clk);
    chk({req, " R4 tx bytes"}, tx_idx - t0, nbytes);
    chk({req, " R4 rx bytes"}, rx_cnt - r0, nbytes);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] e;
      e = txmem[(t0 + i) & 63];
      if (cfg_tx_msb != cfg_rx_msb) e = rev8(e);
      chk({req, " R10 data"}, int'(rxmem[(r0 + i) & 63]), int'(e));
    end
  endtask

  task automatic t_reset();
    chk("R1 cs_n", cs_n, 1);
    chk("R1 busy", busy, 0);
    chk("R1 tx_ready", tx_ready, 0);
    chk("R1 stat", stat_rdata, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sck", sck, 0);
  endtask

  task automatic t_timing(input int hi, input int lo, input int su, input int ho, input int idl);
    cfg_sck_hi = 8'(hi); cfg_sck_lo = 8'(lo); cfg_cs_setup = 8'(su);
    cfg_cs_hold = 8'(ho); cfg_cs_idle = 8'(idl);
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_pkt_len = 10'd3; cfg_pkt_loop = 8'd0;
    run_frame("R9 mode0", 4, 1'b1);
    chk("R7 finish flag", stat_rdata, 2'b01);
    chk("R7 cs released", cs_n, 1);
    chk("R12 irq on finish", irq, 1);
    wait_idle();
    chk("R2 high min", hi_min, hi + 1);
    chk("R2 high max", hi_max, hi + 1);
    chk("R2 low", lo_min, lo + 1);
    chk("R3 setup", first_edge, su + lo + 3);
    chk("R3 hold", tail, ho + 2);
    chk("R3 idle gap", gapc, idl + 1);
    read_stat();
    chk("R12 stat cleared", stat_rdata, 0);
    chk("R12 irq cleared", irq, 0);
  endtask

  task automatic t_framing();
    cfg_pkt_len = 10'd1; cfg_pkt_loop = 8'd2;
    run_frame("R4 2x3", 6, 1'b1);
    wait_idle(); read_stat();
    cfg_pkt_len = 10'd0; cfg_pkt_loop = 8'd0;
    run_frame("R4 1x1", 1, 1'b1);
    wait_idle(); read_stat();
  endtask

  task automatic t_modes();
    cfg_pkt_len = 10'd2; cfg_pkt_loop = 8'd0;
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_tx_msb = 1'b1; cfg_rx_msb = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 idle high", sck, 1);
    run_frame("R9 mode3 R10 msb/lsb", 3, 1'b1);
    wait_idle(); read_stat();
    cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_tx_msb = 1'b0; cfg_rx_msb = 1'b0;
    run_frame("R9 mode1 R10 lsb", 3, 1'b1);
    wait_idle(); read_stat();
    cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_tx_msb = 1'b0; cfg_rx_msb = 1'b1;
    run_frame("R9 mode2 R10 lsb/msb", 3, 1'b1);
    wait_idle(); read_stat();
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_tx_msb = 1'b1; cfg_rx_msb = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_pause();
    int t0;
    cfg_pause_en = 1'b1; cfg_pkt_len = 10'd1; cfg_pkt_loop = 8'd0;
    run_frame("R6 pause seg1", 2, 1'b1);
    chk("R6 pause flag", stat_rdata, 2'b10);
    chk("R6 cs held", cs_n, 0);
    chk("R6 busy", busy, 1);
    chk("R12 pause irq", irq, 1);
    read_stat();
    chk("R12 cleared", stat_rdata, 0);
    t0 = tx_idx;
    pulse_act();
    repeat (40) @(negedge clk);
    chk("R6 act ignored bytes", tx_idx - t0, 0);
    chk("R6 act ignored cs", cs_n, 0);
    run_frame("R6 resume seg2", 2, 1'b0);
    chk("R6 pause again", stat_rdata, 2'b10);
    chk("R6 cs still held", cs_n, 0);
    read_stat();
    cfg_pause_en = 1'b0;
    pulse_rst();
    chk("R8 cs released", cs_n, 1);
    chk("R8 idle", busy, 0);
    t0 = tx_idx;
    pulse_resume();
    repeat (10) @(negedge clk);
    chk("R6 resume ignored busy", busy, 0);
    chk("R6 resume ignored cs", cs_n, 1);
    chk("R6 resume ignored bytes", tx_idx - t0, 0);
  endtask

  task automatic t_act_busy();
    int t0 = tx_idx;
    cfg_pkt_len = 10'd3; cfg_pkt_loop = 8'd1;
    pulse_act();
    repeat (30) @(negedge clk);
    chk("R5 busy", busy, 1);
    pulse_act();
    wait_flag();
    chk("R5 no restart", tx_idx - t0, 8);
    wait_idle(); read_stat();
  endtask

  task automatic t_irq_mask();
    cfg_fin_ie = 1'b0; cfg_pkt_len = 10'd0; cfg_pkt_loop = 8'd0;
    run_frame("R12 masked", 1, 1'b1);
    chk("R12 flag set", stat_rdata, 2'b01);
    chk("R12 irq masked", irq, 0);
    cfg_fin_ie = 1'b1;
    @(negedge clk);
    chk("R12 irq unmasked", irq, 1);
    wait_idle(); read_stat();
    chk("R12 irq off", irq, 0);
  endtask

  task automatic t_reset_midframe();
    cfg_pkt_len = 10'd7; cfg_pkt_loop = 8'd0;
    pulse_act();
    repeat (25) @(negedge clk);
    pulse_rst();
    chk("R8 mid-frame cs", cs_n, 1);
    chk("R8 mid-frame busy", busy, 0);
    repeat (5) @(negedge clk);
    chk("R8 sck idle", sck, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing(1, 2, 3, 1, 4);
    t_timing(3, 0, 0, 4, 0);
    t_framing();
    t_modes();
    t_pause();
    t_act_busy();
    t_irq_mask();
    t_reset_midframe();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule